// File: doc/BRIEF.md
# Pixel clock PLL parameter search

This block turns a requested pixel clock frequency, given in Hz, into divider settings for a display PLL whose reference is a fixed 14,318,180 Hz crystal. On a start pulse it first rejects any target outside the range the PLL can produce. A target inside the range is doubled until it reaches at least 100 MHz, and each doubling is counted into the post-divide field of the divisor byte. The block then tries every reference divider N from 3 to 257. For each N it takes the largest feedback value M whose product with the reference does not exceed N times the scaled target, and it keeps the pair with the smallest frequency error.

Feedback values above 257 can still be used with a divide-by-4 loop divider. For those candidates the error is measured on M with its two low bits cleared, because the register keeps only the upper bits. The result is returned as register codes M-2 and N-2, together with a divisor byte. That byte holds the post-divide count in bits 7:4 and the loop-divide select in bit 2. A host drives one request at a time through a start/busy/done handshake and reads the codes when done pulses.

Top module: `pix_pll_search`

## Requirements
- R1: For an accepted target T, the block reports the (N, M) pair that gives the smallest error over every N from 3 to 257. M is floor(N*Fs/14318180), where Fs is the scaled target, and all arithmetic is exact.
- R2: A target below 3,125,000 or above 220,000,000 is rejected. done_o rises in the cycle after start, err_o is 1, m_code_o, n_code_o and div_o are 0, and busy_o stays low. Both bounds themselves are accepted.
- R3: While the scaled target is below 100,000,000 it is doubled, and each doubling adds 1 to div_o[7:4]. div_o[3], div_o[1] and div_o[0] are always 0 on an accepted result.
- R4: A candidate with 3 <= M <= 257 has error N*Fs - 14318180*M. A candidate with 257 < M <= 1028 has error N*Fs - 14318180*(M with bits 1:0 cleared). A candidate with any other M is skipped.
- R5: A candidate replaces the held best only when its error is strictly smaller, so on equal error the smallest N wins.
- R6: If the winning M exceeds 257, it is shifted right by 2 and div_o[2] is 0 (loop divide by 4). Otherwise M is used unchanged and div_o[2] is 1 (loop divide by 1).
- R7: m_code_o is the final M minus 2, and n_code_o is the winning N minus 2, each truncated to 8 bits.
- R8: An accepted start raises busy_o in the next cycle. done_o is a one-cycle pulse, and busy_o is low while it is high. A start while busy_o is high is ignored.
- R9: err_o, m_code_o, n_code_o and div_o change only in the cycle in which done_o is high, and hold their values until the next result. A start in the done cycle is accepted.
- R10: After reset, busy_o, done_o, err_o and all code outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a search; taken only when idle |
| target_i | input | 32 | Requested pixel clock in Hz, sampled with start |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle result strobe |
| err_o | output | 1 | Target was out of range |
| m_code_o | output | 8 | Feedback divider code (M-2) |
| n_code_o | output | 8 | Reference divider code (N-2) |
| div_o | output | 8 | Post-divide count in bits 7:4, loop-divide-by-1 select in bit 2 |

## Verification
The result strobe of a finished search can coincide with the start of the next request. In that cycle the block must accept the new start and still hold the previous codes on its outputs. The bench provokes this by raising start in the very sample in which it sees done. It then checks that busy is high and that the old codes are unchanged for the whole new search, and that the next strobe carries the codes computed for the new target. A rejected target issued in the done cycle of an accepted search is judged the same way: the error strobe must follow after exactly one cycle.

// File: rtl/pix_pll_pkg.sv
package pix_pll_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCALE,
    ST_DIV,
    ST_SWEEP,
    ST_FIN
  } pll_state_e;

  localparam int unsigned REF_HZ_DEF   = 32'd14318180;
  localparam int unsigned F_MIN_DEF    = 32'd3125000;
  localparam int unsigned F_MAX_DEF    = 32'd220000000;
  localparam int unsigned SCALE_HZ_DEF = 32'd100000000;
endpackage

// File: rtl/pix_pll_prescaler.sv
module pix_pll_prescaler #(
  parameter int unsigned FW       = 32,
  parameter int unsigned SW       = 4,
  parameter int unsigned SCALE_HZ = 100000000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          en_i,
  input  logic [FW-1:0] value_i,
  output logic [FW-1:0] value_o,
  output logic [SW-1:0] shifts_o,
  output logic          ready_o
);
  localparam logic [FW-1:0] LIMIT = FW'(SCALE_HZ);

  logic [FW-1:0] val_q;
  logic [SW-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q <= '0;
      sh_q  <= '0;
    end else if (load_i) begin
      val_q <= value_i;
      sh_q  <= '0;
    end else if (en_i && !ready_o) begin
      val_q <= {val_q[FW-2:0], 1'b0};
      sh_q  <= sh_q + SW'(1);
    end
  end

  assign ready_o  = val_q >= LIMIT;
  assign value_o  = val_q;
  assign shifts_o = sh_q;
endmodule

// File: rtl/pix_pll_divider.sv
module pix_pll_divider #(
  parameter int unsigned FW     = 32,
  parameter int unsigned QW     = 5,
  parameter int unsigned RW     = 24,
  parameter int unsigned REF_HZ = 14318180
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          en_i,
  input  logic [FW-1:0] dividend_i,
  output logic [QW-1:0] quot_o,
  output logic [RW-1:0] rem_o,
  output logic          ready_o
);
  localparam logic [FW-1:0] DIVISOR = FW'(REF_HZ);

  logic [FW-1:0] rem_q;
  logic [QW-1:0] quot_q;

  // repeated subtraction: quotient is small, so a few cycles suffice
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      quot_q <= '0;
    end else if (load_i) begin
      rem_q  <= dividend_i;
      quot_q <= '0;
    end else if (en_i && !ready_o) begin
      rem_q  <= rem_q - DIVISOR;
      quot_q <= quot_q + QW'(1);
    end
  end

  assign ready_o = rem_q < DIVISOR;
  assign quot_o  = quot_q;
  assign rem_o   = rem_q[RW-1:0];
endmodule

// File: rtl/pix_pll_cand_eval.sv
module pix_pll_cand_eval #(
  parameter int unsigned MW     = 14,
  parameter int unsigned RW     = 24,
  parameter int unsigned EW     = 26,
  parameter int unsigned REF_HZ = 14318180,
  parameter int unsigned M_LO   = 3,
  parameter int unsigned M_HI   = 257,
  parameter int unsigned M_HI4  = 1028
) (
  input  logic [MW-1:0] m_i,
  input  logic [RW-1:0] rem_i,
  output logic          ok_o,
  output logic [EW-1:0] err_o
);
  localparam logic [MW-1:0] LO_V  = MW'(M_LO);
  localparam logic [MW-1:0] HI_V  = MW'(M_HI);
  localparam logic [MW-1:0] HI4_V = MW'(M_HI4);
  localparam logic [EW-1:0] REF_E = EW'(REF_HZ);

  logic fine, coarse;

  // rem_i = N*Fs - REF*M exactly; clearing M[1:0] adds REF*M[1:0]
  always_comb begin
    fine   = (m_i >= LO_V) && (m_i <= HI_V);
    coarse = (m_i > HI_V) && (m_i <= HI4_V);
    ok_o   = fine || coarse;
    err_o  = EW'(rem_i) + (coarse ? REF_E * EW'(m_i[1:0]) : '0);
  end
endmodule

// File: rtl/pix_pll_search.sv
module pix_pll_search
  import pix_pll_pkg::*;
#(
  parameter int unsigned FW       = 32,
  parameter int unsigned QW       = 5,
  parameter int unsigned REF_HZ   = REF_HZ_DEF,
  parameter int unsigned F_MIN_HZ = F_MIN_DEF,
  parameter int unsigned F_MAX_HZ = F_MAX_DEF,
  parameter int unsigned SCALE_HZ = SCALE_HZ_DEF,
  parameter int unsigned N_MIN    = 3,
  parameter int unsigned N_MAX    = 257,
  parameter int unsigned M_LO     = 3,
  parameter int unsigned M_HI     = 257,
  parameter int unsigned M_HI4    = 1028
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [FW-1:0] target_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic [7:0]    m_code_o,
  output logic [7:0]    n_code_o,
  output logic [7:0]    div_o
);
  localparam int unsigned SW = 4;
  localparam int unsigned NW = $clog2(N_MAX + 2);
  localparam int unsigned RW = $clog2(REF_HZ + 1);
  localparam int unsigned MW = $clog2((N_MAX + 1) * (2 ** QW) + 1);
  localparam int unsigned EW = $clog2(4 * REF_HZ + 1);

  localparam logic [FW-1:0] F_MIN_V = FW'(F_MIN_HZ);
  localparam logic [FW-1:0] F_MAX_V = FW'(F_MAX_HZ);
  localparam logic [NW-1:0] N_MIN_V = NW'(N_MIN);
  localparam logic [NW-1:0] N_MAX_V = NW'(N_MAX);
  localparam logic [MW-1:0] M_HI_V  = MW'(M_HI);
  localparam logic [RW:0]   REF_R   = (RW + 1)'(REF_HZ);

  pll_state_e state_q;

  logic [NW-1:0] n_q, best_n_q;
  logic [MW-1:0] mq_q, best_m_q, mq_next, m_fin;
  logic [RW-1:0] mr_q, mr_next;
  logic [RW:0]   rem_sum;
  logic [EW-1:0] best_e_q, cand_err;
  logic          cand_ok, take, wrap, loop1, in_range;
  logic          done_q, err_q;
  logic [7:0]    m_code_q, n_code_q, div_q;

  logic [FW-1:0] pre_value;
  logic [SW-1:0] pre_shifts;
  logic          pre_ready;
  logic [QW-1:0] dv_quot;
  logic [RW-1:0] dv_rem;
  logic          dv_ready;

  assign in_range = (target_i >= F_MIN_V) && (target_i <= F_MAX_V);

  pix_pll_prescaler #(
    .FW(FW), .SW(SW), .SCALE_HZ(SCALE_HZ)
  ) u_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (state_q == ST_IDLE && start_i && in_range),
    .en_i    (state_q == ST_SCALE),
    .value_i (target_i),
    .value_o (pre_value),
    .shifts_o(pre_shifts),
    .ready_o (pre_ready)
  );

  pix_pll_divider #(
    .FW(FW), .QW(QW), .RW(RW), .REF_HZ(REF_HZ)
  ) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (state_q == ST_SCALE && pre_ready),
    .en_i      (state_q == ST_DIV),
    .dividend_i(pre_value),
    .quot_o    (dv_quot),
    .rem_o     (dv_rem),
    .ready_o   (dv_ready)
  );

  pix_pll_cand_eval #(
    .MW(MW), .RW(RW), .EW(EW), .REF_HZ(REF_HZ),
    .M_LO(M_LO), .M_HI(M_HI), .M_HI4(M_HI4)
  ) u_eval (
    .m_i  (mq_q),
    .rem_i(mr_q),
    .ok_o (cand_ok),
    .err_o(cand_err)
  );

  // M(N+1) = M(N) + q + carry of remainder accumulation
  always_comb begin
    rem_sum = {1'b0, mr_q} + {1'b0, dv_rem};
    wrap    = rem_sum >= REF_R;
    mq_next = mq_q + MW'(dv_quot) + MW'(wrap);
    mr_next = wrap ? RW'(rem_sum - REF_R) : rem_sum[RW-1:0];
    take    = (n_q >= N_MIN_V) && cand_ok && (cand_err < best_e_q);
    loop1   = best_m_q <= M_HI_V;
    m_fin   = loop1 ? best_m_q : (best_m_q >> 2);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      n_q      <= '0;
      mq_q     <= '0;
      mr_q     <= '0;
      best_e_q <= '1;
      best_m_q <= '0;
      best_n_q <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      m_code_q <= '0;
      n_code_q <= '0;
      div_q    <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            if (in_range) begin
              state_q <= ST_SCALE;
            end else begin
              done_q   <= 1'b1;
              err_q    <= 1'b1;
              m_code_q <= '0;
              n_code_q <= '0;
              div_q    <= '0;
            end
          end
        end
        ST_SCALE: if (pre_ready) state_q <= ST_DIV;
        ST_DIV: begin
          if (dv_ready) begin
            state_q  <= ST_SWEEP;
            n_q      <= NW'(1);
            mq_q     <= MW'(dv_quot);
            mr_q     <= dv_rem;
            best_e_q <= '1;
            best_m_q <= '0;
            best_n_q <= '0;
          end
        end
        ST_SWEEP: begin
          if (take) begin
            best_e_q <= cand_err;
            best_m_q <= mq_q;
            best_n_q <= n_q;
          end
          n_q  <= n_q + NW'(1);
          mq_q <= mq_next;
          mr_q <= mr_next;
          if (n_q == N_MAX_V) state_q <= ST_FIN;
        end
        ST_FIN: begin
          done_q   <= 1'b1;
          err_q    <= 1'b0;
          m_code_q <= 8'(m_fin - MW'(2));
          n_code_q <= 8'(best_n_q - NW'(2));
          div_q    <= {pre_shifts, 1'b0, loop1, 2'b00};
          state_q  <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o   = state_q != ST_IDLE;
  assign done_o   = done_q;
  assign err_o    = err_q;
  assign m_code_o = m_code_q;
  assign n_code_o = n_code_q;
  assign div_o    = div_q;
endmodule

// File: rtl/pix_pll_search_chk.sv
module pix_pll_search_chk #(
  parameter int unsigned FW       = 32,
  parameter int unsigned F_MIN_HZ = 3125000,
  parameter int unsigned F_MAX_HZ = 220000000
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [FW-1:0] target_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          err_o,
  input logic [7:0]    m_code_o,
  input logic [7:0]    n_code_o,
  input logic [7:0]    div_o
);
  localparam logic [FW-1:0] MIN_V = FW'(F_MIN_HZ);
  localparam logic [FW-1:0] MAX_V = FW'(F_MAX_HZ);

  logic bad_t;
  assign bad_t = (target_i < MIN_V) || (target_i > MAX_V);

  AST_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && bad_t) |=> (done_o && err_o && !busy_o)); // R2

  AST_ERR_CODES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> (m_code_o == 8'd0 && n_code_o == 8'd0 && div_o == 8'd0)); // R2

  AST_DIV_FIELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o) |-> (div_o[3] == 1'b0 && div_o[1:0] == 2'b00)); // R3

  AST_LOOP4_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o && !div_o[2]) |-> (m_code_o >= 8'd62)); // R6

  AST_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && !bad_t) |=> (busy_o && !done_o)); // R8

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> !done_o); // R8

  AST_BUSY_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !done_o); // R8

  AST_BUSY_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i)); // R8

  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({err_o, m_code_o, n_code_o, div_o}) |-> done_o); // R9
endmodule

bind pix_pll_search pix_pll_search_chk #(
  .FW(FW), .F_MIN_HZ(F_MIN_HZ), .F_MAX_HZ(F_MAX_HZ)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .target_i(target_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .err_o   (err_o),
  .m_code_o(m_code_o),
  .n_code_o(n_code_o),
  .div_o   (div_o)
);

// File: tb/pix_pll_search_tb.sv
module pix_pll_search_tb;
  localparam longint unsigned REF = 64'd14318180;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] target = '0;
  logic        busy, done, err;
  logic [7:0]  m_code, n_code, div;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pix_pll_search u_dut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .start_i (start),
    .target_i(target),
    .busy_o  (busy),
    .done_o  (done),
    .err_o   (err),
    .m_code_o(m_code),
    .n_code_o(n_code),
    .div_o   (div)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint unsigned act, input longint unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic void model(input logic [31:0] t, output logic e,
                                output logic [7:0] mc, output logic [7:0] nc,
                                output logic [7:0] dv);
    longint unsigned ft, m, er, be, bm, bn;
    int unsigned d;
    mc = 8'd0; nc = 8'd0; dv = 8'd0;
    if (t < 32'd3125000 || t > 32'd220000000) begin
      e = 1'b1;
      return;
    end
    e = 1'b0;
    ft = 64'(t);
    d = 0;
    while (ft < 64'd100000000) begin
      ft = ft * 2;
      d = d + 16;
    end
    be = '1; bm = 0; bn = 0;
    for (int n = 3; n <= 257; n++) begin
      longint unsigned nn = 64'(n);
      m = (nn * ft) / REF;
      if (m >= 3 && m <= 257) er = nn * ft - REF * m;
      else if (m > 257 && m <= 1028) er = nn * ft - REF * (m & ~64'd3);
      else continue;
      if (er < be) begin
        be = er; bm = m; bn = nn;
      end
    end
    if (bm > 257) bm = bm >> 2;
    else d = d | 4;
    mc = 8'(bm - 2);
    nc = 8'(bn - 2);
    dv = 8'(d);
  endfunction

  task automatic pulse_start(input logic [31:0] t);
    start  = 1'b1;
    target = t;
    @(negedge clk);
    start  = 1'b0;
  endtask

  task automatic wait_done(output int lat);
    lat = 1;
    while (!done && lat < 2000) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic compare(input logic [31:0] t, input string req);
    logic e; logic [7:0] mc, nc, dv;
    model(t, e, mc, nc, dv);
    check(done == 1'b1, req, "done strobe", 64'(done), 1);
    check(err == e, req, "err", 64'(err), 64'(e));
    check(m_code == mc, req, "m_code", 64'(m_code), 64'(mc));
    check(n_code == nc, req, "n_code", 64'(n_code), 64'(nc));
    check(div == dv, req, "div", 64'(div), 64'(dv));
  endtask

  task automatic test_reset();
    check(busy == 0 && done == 0 && err == 0, "R10", "flags after reset",
          64'({busy, done, err}), 0);
    check(m_code == 0 && n_code == 0 && div == 0, "R10", "codes after reset",
          64'({m_code, n_code, div}), 0);
  endtask

  task automatic test_reject(input logic [31:0] t);
    int lat;
    pulse_start(t);
    check(busy == 1'b0, "R2", "busy on reject", 64'(busy), 0);
    wait_done(lat);
    check(lat == 1, "R2", "reject latency", 64'(lat), 1);
    check(err == 1'b1, "R2", "err on reject", 64'(err), 1);
    check(m_code == 0 && n_code == 0 && div == 0, "R2", "codes on reject",
          64'({m_code, n_code, div}), 0);
    @(negedge clk);
  endtask

  task automatic test_search(input logic [31:0] t, input string req);
    int lat;
    pulse_start(t);
    check(busy == 1'b1, "R8", "busy after accepted start", 64'(busy), 1);
    wait_done(lat);
    check(busy == 1'b0, "R8", "busy low with done", 64'(busy), 0);
    compare(t, req);
    @(negedge clk);
    check(done == 1'b0, "R8", "done is one cycle", 64'(done), 0);
  endtask

  task automatic test_bounds();
    test_search(32'd3125000, "R2");
    check(div[7:4] == 4'd5, "R3", "five doublings at lower bound", 64'(div[7:4]), 5);
    test_search(32'd220000000, "R2");
    check(div[7:4] == 4'd0, "R3", "no doubling at upper bound", 64'(div[7:4]), 0);
    test_search(32'd100000000, "R3");
    check(div[7:4] == 4'd0, "R3", "no doubling at 100 MHz", 64'(div[7:4]), 0);
    test_search(32'd99999999, "R3");
    check(div[7:4] == 4'd1, "R3", "one doubling below 100 MHz", 64'(div[7:4]), 1);
  endtask

  task automatic test_typical();
    logic [31:0] tl [8] = '{32'd25175000, 32'd31500000, 32'd40000000, 32'd65000000,
                            32'd108000000, 32'd135000000, 32'd7654321, 32'd219999937};
    for (int i = 0; i < 8; i++) begin
      test_search(tl[i], "R1");
      compare_tags(tl[i]);
    end
  endtask

  task automatic compare_tags(input logic [31:0] t);
    logic e; logic [7:0] mc, nc, dv;
    model(t, e, mc, nc, dv);
    check(div[2] == dv[2], "R6", "loop divide select", 64'(div[2]), 64'(dv[2]));
    check(m_code == mc, "R4", "m_code under error windows", 64'(m_code), 64'(mc));
    check(n_code == nc, "R7", "n_code offset", 64'(n_code), 64'(nc));
  endtask

  task automatic test_tie();
    // exact multiples of the reference give zero error at every N: first N kept
    test_search(32'd100227260, "R5");
    check(n_code == 8'd1, "R5", "tie keeps N=3", 64'(n_code), 1);
    check(m_code == 8'd19, "R7", "M=21 code", 64'(m_code), 19);
    check(div == 8'h04, "R6", "loop divide 1", 64'(div), 4);
    test_search(32'd114545440, "R5");
    check(n_code == 8'd1 && m_code == 8'd22, "R5", "tie at 8x ref",
          64'({m_code, n_code}), 64'({8'd22, 8'd1}));
  endtask

  task automatic test_busy_ignore();
    int lat;
    pulse_start(32'd65000000);
    repeat (10) @(negedge clk);
    pulse_start(32'd3000000);
    check(busy == 1'b1 && done == 1'b0, "R8", "start while busy ignored",
          64'({busy, done}), 2);
    repeat (40) @(negedge clk);
    pulse_start(32'd40000000);
    wait_done(lat);
    compare(32'd65000000, "R8");
    @(negedge clk);
  endtask

  task automatic test_back_to_back();
    int lat;
    logic [7:0] om, on, od;
    test_search(32'd25175000, "R9");
    repeat (20) @(negedge clk);
    check(done == 1'b0, "R9", "no strobe while idle", 64'(done), 0);
    compare_hold(32'd25175000);
    pulse_start(32'd135000000);
    wait_done(lat);
    om = m_code; on = n_code; od = div;
    pulse_start(32'd40000000);
    check(busy == 1'b1, "R9", "start in done cycle accepted", 64'(busy), 1);
    check(m_code == om && n_code == on && div == od, "R9", "old codes held",
          64'({m_code, n_code, div}), 64'({om, on, od}));
    repeat (100) @(negedge clk);
    check(m_code == om && n_code == on && div == od, "R9", "held mid search",
          64'({m_code, n_code, div}), 64'({om, on, od}));
    wait_done(lat);
    compare(32'd40000000, "R9");
    pulse_start(32'd250000000);
    wait_done(lat);
    check(lat == 1 && err == 1'b1, "R2", "reject in done cycle",
          64'({lat[7:0], err}), 64'({8'd1, 1'b1}));
    @(negedge clk);
  endtask

  task automatic compare_hold(input logic [31:0] t);
    logic e; logic [7:0] mc, nc, dv;
    model(t, e, mc, nc, dv);
    check(m_code == mc && n_code == nc && div == dv && err == e, "R9",
          "outputs hold after done", 64'({m_code, n_code, div}), 64'({mc, nc, dv}));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_reject(32'd3124999);
    test_reject(32'd220000001);
    test_reject(32'd0);
    test_reject(32'hFFFFFFFF);
    test_bounds();
    test_typical();
    test_tie();
    test_busy_ignore();
    test_back_to_back();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule